// File: doc/BRIEF.md
# Directed rounding result fixup

This unit post-processes a result that an arithmetic datapath has already rounded, either to nearest or toward zero, and corrects it so that it obeys rounding toward plus infinity or toward minus infinity. It takes the 64-bit destination value as two 32-bit words, the source operand words the result came from, one inexact indication per 32-bit lane, the rounding mode, the data format and the operation class. When the result was inexact and a directed mode is selected, it moves the value by one unit in its least significant position.

A float result moves away from zero. A rounded integer conversion moves toward the selected infinity, so a negative integer is decremented under minus-infinity rounding. Unsigned conversions are always treated as positive. A signed conversion that produced zero takes its sign from the source word that was converted. The corrected value is registered and appears one cycle after the valid strobe, together with a done pulse.

Top module: `dirround_fixup`

## Requirements
- R1: `out_done` is high exactly in the cycle after a cycle with `in_valid` high, and `out_val` carries the result of that request from that cycle on.
- R2: With no relevant inexact indication the value passes unchanged. For single and double format only `inx_lo` counts. For paired format (`fmt`=10) each lane counts its own indication (`inx_lo` for the low word, `inx_hi` for the high word).
- R3: Rounding modes 00 (nearest) and 01 (toward zero) pass the value unchanged. Mode 10 is plus infinity and mode 11 is minus infinity.
- R4: Operation class 011 (truncating conversion) and class 100 (compare) pass the value unchanged in every mode. Classes 101 to 111 also pass unchanged.
- R5: Under mode 10, an inexact result whose sign is clear is incremented by one. This applies to class 000 (float), class 001 (signed rounding conversion) and class 010 (unsigned rounding conversion).
- R6: Under mode 11, an inexact result whose sign is set is incremented by one for class 000 and decremented by one for class 001.
- R7: Class 010 results are treated as positive. They are incremented under mode 10 and never changed under mode 11.
- R8: For class 001, a lane whose result word is zero takes its sign from bit 31 of the matching source word. Otherwise the sign is bit 31 of the result word.
- R9: In double format (`fmt`=01) with class 000, the full 64-bit value is incremented, with carry from the low word into the high word. The sign is bit 31 of the high result word.
- R10: In double format with class 001 or 010, only the low word is adjusted and the high word passes unchanged. The sign is bit 31 of the low result word, or bit 31 of `src_hi` when the low word is zero.
- R11: In paired format, each 32-bit lane is adjusted on its own, using its own inexact indication and its own sign, with no carry between the lanes.
- R12: In single format (`fmt`=00, and also 11), the high word passes unchanged and the low word is adjusted using its own sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| rmode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 plus infinity, 11 minus infinity |
| fmt | input | 2 | Format: 00 single, 01 double, 10 paired single |
| opcls | input | 3 | Class: 000 float, 001 signed conv, 010 unsigned conv, 011 truncating conv, 100 compare |
| dst_hi | input | 32 | High word of the datapath result |
| dst_lo | input | 32 | Low word of the datapath result |
| src_hi | input | 32 | High word of the converted source operand |
| src_lo | input | 32 | Low word of the converted source operand |
| inx_lo | input | 1 | Low lane inexact indication |
| inx_hi | input | 1 | High lane inexact indication |
| out_val | output | 64 | Corrected value, high word in bits 63:32 |
| out_done | output | 1 | Pulse one cycle after `in_valid` |

## Verification
The sweep crosses every mode, format, class and inexact pattern with operands chosen to hit specific corner cases. These are a zero integer result paired with a negative source, a low word of all ones under double precision, and lanes of opposite sign. A design that took the sign of zero from the result would miss the decrement that R8 calls for. A design that dropped the carry would leave the high word of a double stale. A design that shared one gate or sign across the paired lanes would adjust the wrong lane. Truncating and compare classes are swept under both directed modes, so any leak of an adjustment into them shows up as a changed value.

// File: rtl/dirround_fixup.sv
module dirround_fixup #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     rmode,
  input  logic [1:0]     fmt,
  input  logic [2:0]     opcls,
  input  logic [W-1:0]   dst_hi,
  input  logic [W-1:0]   dst_lo,
  input  logic [W-1:0]   src_hi,
  input  logic [W-1:0]   src_lo,
  input  logic           inx_lo,
  input  logic           inx_hi,
  output logic [2*W-1:0] out_val,
  output logic           out_done
);
  localparam logic [1:0] M_PINF = 2'b10;
  localparam logic [1:0] M_MINF = 2'b11;

  logic is_dbl, is_pair, is_flt, is_sc, is_uc, adj_ok;
  logic lo_zero, hi_zero, sgn_lo, sgn_hi;
  logic inc_lo, dec_lo, inc_hi, dec_hi;
  logic [W-1:0] add_lo, add_hi;
  logic [2*W-1:0] nxt;

  assign is_dbl  = (fmt == 2'b01);
  assign is_pair = (fmt == 2'b10);
  assign is_flt  = (opcls == 3'd0);
  assign is_sc   = (opcls == 3'd1);
  assign is_uc   = (opcls == 3'd2);
  assign adj_ok  = (is_flt | is_sc | is_uc) & rmode[1];

  assign lo_zero = (dst_lo == '0);
  assign hi_zero = (dst_hi == '0);

  assign sgn_lo = is_uc ? 1'b0 :
                  (is_sc && lo_zero) ? src_lo[W-1] : dst_lo[W-1];

  always_comb begin
    if (is_uc)
      sgn_hi = 1'b0;
    else if (is_sc && is_dbl)
      sgn_hi = lo_zero ? src_hi[W-1] : dst_lo[W-1];
    else if (is_sc && hi_zero)
      sgn_hi = src_hi[W-1];
    else
      sgn_hi = dst_hi[W-1];
  end

  logic sel_sgn_lo, gate_lo;
  assign sel_sgn_lo = is_dbl ? sgn_hi : sgn_lo;
  assign gate_lo    = adj_ok & inx_lo;

  assign inc_lo = gate_lo & (((rmode == M_PINF) & ~sel_sgn_lo) |
                             ((rmode == M_MINF) & sel_sgn_lo & is_flt));
  assign dec_lo = gate_lo & (rmode == M_MINF) & sel_sgn_lo & ~is_flt;
  assign inc_hi = adj_ok & inx_hi & (((rmode == M_PINF) & ~sgn_hi) |
                                     ((rmode == M_MINF) & sgn_hi & is_flt));
  assign dec_hi = adj_ok & inx_hi & (rmode == M_MINF) & sgn_hi & ~is_flt;

  assign add_lo = dec_lo ? '1 : {{(W-1){1'b0}}, inc_lo};
  assign add_hi = dec_hi ? '1 : {{(W-1){1'b0}}, inc_hi};

  always_comb begin
    nxt = {dst_hi, dst_lo};
    if (is_dbl && is_flt)
      nxt = {dst_hi, dst_lo} + {{(2*W-1){1'b0}}, inc_lo};
    else if (is_pair)
      nxt = {dst_hi + add_hi, dst_lo + add_lo};
    else
      nxt = {dst_hi, dst_lo + add_lo};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_val  <= '0;
      out_done <= 1'b0;
    end else begin
      out_done <= in_valid;
      if (in_valid) out_val <= nxt;
    end
  end
endmodule

module dirround_fixup_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [1:0]     rmode,
  input logic [1:0]     fmt,
  input logic [2:0]     opcls,
  input logic [W-1:0]   dst_hi,
  input logic [W-1:0]   dst_lo,
  input logic           inx_lo,
  input logic           inx_hi,
  input logic [2*W-1:0] out_val,
  input logic           out_done
);
  a_r1_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  a_r2_no_inexact_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !inx_lo && !inx_hi) |=> out_val == $past({dst_hi, dst_lo}));
  a_r3_nondirected_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rmode[1]) |=> out_val == $past({dst_hi, dst_lo}));
  a_r4_trunc_cmp_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcls >= 3'd3) |=> out_val == $past({dst_hi, dst_lo}));
  a_r7_unsigned_minf_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcls == 3'd2 && rmode == 2'b11) |=> out_val == $past({dst_hi, dst_lo}));
  a_r10_dbl_conv_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b01 && (opcls == 3'd1 || opcls == 3'd2)) |=> out_val[2*W-1:W] == $past(dst_hi));
  a_r12_single_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (fmt == 2'b00 || fmt == 2'b11)) |=> out_val[2*W-1:W] == $past(dst_hi));
endmodule

bind dirround_fixup dirround_fixup_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rmode(rmode), .fmt(fmt),
  .opcls(opcls), .dst_hi(dst_hi), .dst_lo(dst_lo), .inx_lo(inx_lo),
  .inx_hi(inx_hi), .out_val(out_val), .out_done(out_done)
);

// File: tb/sim_dirround_fixup.sv
module sim_dirround_fixup;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] rmode = 0, fmt = 0;
  logic [2:0] opcls = 0;
  logic [31:0] dst_hi = 0, dst_lo = 0, src_hi = 0, src_lo = 0;
  logic inx_lo = 0, inx_hi = 0;
  logic [63:0] out_val;
  logic out_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dirround_fixup u0 (.*);

  function automatic logic [31:0] lane_step(input logic [1:0] m, input logic [2:0] c,
                                            input logic s, input logic [31:0] v);
    if (m == 2'b10 && !s) return v + 32'd1;
    if (m == 2'b11 && s) return (c == 3'd0) ? v + 32'd1 : v - 32'd1;
    return v;
  endfunction

  function automatic logic [63:0] expect_val(input logic [1:0] m, input logic [1:0] f,
      input logic [2:0] c, input logic il, input logic ih,
      input logic [31:0] dh, input logic [31:0] dl, input logic [31:0] sh, input logic [31:0] sl);
    logic slo, shi;
    if (!m[1] || c > 3'd2) return {dh, dl};
    slo = (c == 3'd2) ? 1'b0 : (c == 3'd1 && dl == 0) ? sl[31] : dl[31];
    shi = (c == 3'd2) ? 1'b0 : (c == 3'd1 && dh == 0) ? sh[31] : dh[31];
    if (f == 2'b01) begin
      if (!il) return {dh, dl};
      if (c == 3'd0) return (m == 2'b10 && !dh[31]) || (m == 2'b11 && dh[31]) ? {dh, dl} + 64'd1 : {dh, dl};
      return {dh, lane_step(m, c, (c == 3'd2) ? 1'b0 : (dl == 0 ? sh[31] : dl[31]), dl)};
    end
    if (f == 2'b10)
      return {ih ? lane_step(m, c, shi, dh) : dh, il ? lane_step(m, c, slo, dl) : dl};
    return {dh, il ? lane_step(m, c, slo, dl) : dl};
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [1:0] f, input logic [2:0] c,
                                   input logic il, input logic ih, input logic [31:0] dl);
    if (!m[1]) return "R3";
    if (c > 3'd2) return "R4";
    if (!il && !(f == 2'b10 && ih)) return "R2";
    if (f == 2'b10) return "R11";
    if (f == 2'b01) return (c == 3'd0) ? "R9" : "R10";
    if (c == 3'd2) return "R7";
    if (c == 3'd1 && dl == 0) return "R8";
    return (m == 2'b11) ? "R6" : "R5";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [1:0] f, input logic [2:0] c,
                     input logic il, input logic ih, input logic [31:0] dh, input logic [31:0] dl,
                     input logic [31:0] sh, input logic [31:0] sl, input string tag);
    @(negedge clk);
    rmode = m; fmt = f; opcls = c; inx_lo = il; inx_hi = ih;
    dst_hi = dh; dst_lo = dl; src_hi = sh; src_lo = sl; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({tag, " done"}, {63'd0, out_done}, 64'd1);
    check(tag, out_val, expect_val(m, f, c, il, ih, dh, dl, sh, sl));
    @(negedge clk);
    check("R1 done pulse ends", {63'd0, out_done}, 64'd0);
  endtask

  initial begin
    logic [31:0] pd_hi [6], pd_lo [6], ps_hi [6], ps_lo [6];
    pd_hi = '{32'h3f800000, 32'hbf800000, 32'h0, 32'h0, 32'h12345678, 32'h80000000};
    pd_lo = '{32'h40000000, 32'hc0000000, 32'h0, 32'h0, 32'hffffffff, 32'h00000005};
    ps_hi = '{32'h0, 32'h0, 32'h80000000, 32'h0, 32'h80000000, 32'h0};
    ps_lo = '{32'h0, 32'h0, 32'h80000000, 32'h0, 32'h0, 32'h80000000};
    repeat (3) @(negedge clk);
    check("R1 reset done", {63'd0, out_done}, 64'd0);
    check("R1 reset value", out_val, 64'd0);
    rst_n = 1;
    run(2'b10, 2'b00, 3'd0, 1, 0, 32'h11111111, 32'h3f800000, 0, 0, "R12 single hi kept");
    run(2'b11, 2'b00, 3'd1, 1, 0, 0, 0, 0, 32'h80000000, "R8 zero takes src sign");
    run(2'b11, 2'b00, 3'd1, 1, 0, 0, 32'hfffffffd, 0, 0, "R6 int decrement");
    run(2'b10, 2'b01, 3'd0, 1, 0, 32'h0, 32'hffffffff, 0, 0, "R9 carry into hi");
    run(2'b11, 2'b01, 3'd1, 1, 0, 32'h7, 0, 32'h80000000, 0, "R10 sign from src hi");
    run(2'b11, 2'b10, 3'd1, 0, 1, 32'hfffffff0, 32'hfffffff0, 0, 0, "R11 hi lane only");
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 3; f++)
        for (int c = 0; c < 5; c++)
          for (int ix = 0; ix < 4; ix++)
            for (int p = 0; p < 6; p++)
              run(m[1:0], f[1:0], c[2:0], ix[0], ix[1], pd_hi[p], pd_lo[p], ps_hi[p], ps_lo[p],
                  tag_of(m[1:0], f[1:0], c[2:0], ix[0], ix[1], pd_lo[p]));
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin repeat (100000) @(posedge clk); errors++; checks++; $display("FAIL R1 watchdog actual=hung expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule